// File: doc/BRIEF.md
# Paged Access Protection Vector Checker

This block decides whether a bus access may proceed. Each request carries a 32-bit address, a read/write flag and the number of the master group that issued it. Every group has its own configuration: a protection mode, a page size and the base address of a bit vector held in memory. In the vector, one bit stands for one page of the 4 GiB address space, and a set bit marks that page as protected.

For the modes that consult the vector, the checker works out which 128-bit line of the vector covers the page and reads that line over a simple memory read port. It keeps recently used lines in a small direct-mapped cache, with a tag made of the group number and the line index. Each mode has a fixed decision latency: 0 cycles, 1 cycle or at least 4 cycles. Only one request is in flight at a time. The requester waits on `req_ready` until the current decision has been given.

Top module: `apv_checker`

## Requirements
- R1: After reset, `req_ready` is 1 and `dec_valid` and `mem_req_valid` are 0.
- R2: Mode 0 (off) gives `dec_allow`=1 in the same cycle the request is accepted, and no fetch is made.
- R3: Mode 1 (write-protect) handles reads like R2: allowed in the same cycle, with no fetch. For writes it consults the vector, and a set bit denies the write.
- R4: Mode 3 (passthrough) allows the access one cycle after acceptance. Modes 4 to 7 (inactive) deny the access one cycle after acceptance. Neither fetches.
- R5: Mode 2 (full) consults the vector for both reads and writes. A set bit gives `dec_allow`=0 and a clear bit gives `dec_allow`=1.
- R6: A 3-bit shift field S sets the page size to 4 KiB << S. The line index is addr[31:19+S], the bit select is addr[18+S:12+S], and the fetch address is base + 16 × line index. The base must be 16-byte aligned and aligned to the vector size.
- R7: A bit select of k tests bit 127−k of the fetched 128-bit line, so page 0 of a line maps to bit 127.
- R8: On a miss, one fetch is issued. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. The response must arrive one cycle after the handshake. With a ready memory, the decision comes 4 cycles after acceptance, and each memory stall cycle adds one cycle.
- R9: A vector access to a line that is already cached, for the same group, is decided 1 cycle after acceptance without a fetch.
- R10: While `cache_en`=0, every vector access fetches (4-cycle latency) and no line is filled.
- R11: A pulse on `cache_flush` invalidates every line, so the next access to a previously cached line fetches again.
- R12: From the accept edge of a request with nonzero latency until its decision cycle, `req_ready` is 0. At most one fetch is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cache_en | input | 1 | Enables cache lookup and fill |
| cache_flush | input | 1 | Invalidates all cache lines |
| cfg_base | input | NUM_GROUPS*32 | Per-group vector base address |
| cfg_mode | input | NUM_GROUPS*3 | Per-group protection mode |
| cfg_pshift | input | NUM_GROUPS*3 | Per-group page-size shift S |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_group | input | GRP_W | Master group number |
| mem_req_valid | output | 1 | Vector line fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 32 | Byte address of the 128-bit line |
| mem_rsp_valid | input | 1 | Line data present |
| mem_rsp_data | input | 128 | Fetched vector line |
| dec_valid | output | 1 | Decision pulse |
| dec_allow | output | 1 | 1 = access permitted |

## Verification
Some rules are checked by the embedded assertions on every cycle:
- A pending fetch holds its address steady until `mem_req_ready` is seen.
- Fetch addresses stay line aligned.
- Only one fetch is outstanding at a time.
- Accepts and decisions alternate.
- A same-cycle decision is always an allow.
- A flush leaves no line hitting.

Other behaviour can only be shown by the bench's scenarios, which compare each decision against values computed from the requirements:
- the exact per-mode latencies;
- the address slicing for different page sizes;
- the bit-127 ordering;
- hit versus miss after stalls, cache disable and flush.

// File: rtl/apv_pkg.sv
package apv_pkg;
   localparam int unsigned VEC_LINE_W      = 128;
   localparam int unsigned LINE_BYTES_LOG2 = $clog2(VEC_LINE_W / 8);
   localparam int unsigned MODE_W          = 3;

   localparam logic [MODE_W-1:0] MODE_OFF   = 3'd0;
   localparam logic [MODE_W-1:0] MODE_WPROT = 3'd1;
   localparam logic [MODE_W-1:0] MODE_FULL  = 3'd2;
   localparam logic [MODE_W-1:0] MODE_PASS  = 3'd3;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOOKUP = 3'd1,
      ST_FETCH  = 3'd2,
      ST_WAIT   = 3'd3,
      ST_RESP   = 3'd4
   } chk_state_e;
endpackage

// File: rtl/apv_page_index.sv
module apv_page_index
   import apv_pkg::*;
#(
   parameter  int unsigned ADDR_W        = 32,
   parameter  int unsigned PAGE_LOG2_MIN = 12,
   parameter  int unsigned SHIFT_W       = 3,
   parameter  int unsigned SEL_W         = 7,
   localparam int unsigned LIDX_W        = ADDR_W - PAGE_LOG2_MIN - SEL_W
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [ADDR_W-1:0]  base,
   input  logic [SHIFT_W-1:0] shift,
   output logic [LIDX_W-1:0]  line_idx,
   output logic [SEL_W-1:0]   bit_pos,
   output logic [ADDR_W-1:0]  fetch_addr
);
   localparam int unsigned AMT_W = $clog2(ADDR_W) + 1;

   if (PAGE_LOG2_MIN + SEL_W + (2 ** SHIFT_W) - 1 > ADDR_W) begin : g_bad_shift
      $error("page shift range exceeds address width");
   end

   logic [AMT_W-1:0]  amt;
   logic [ADDR_W-1:0] page_num;

   assign amt        = AMT_W'(PAGE_LOG2_MIN) + AMT_W'(shift);
   assign page_num   = addr >> amt;
   assign line_idx   = page_num[SEL_W +: LIDX_W];
   assign bit_pos    = SEL_W'((1 << SEL_W) - 1) - page_num[SEL_W-1:0];
   assign fetch_addr = base + (ADDR_W'(line_idx) << LINE_BYTES_LOG2);
endmodule

// File: rtl/apv_line_cache.sv
module apv_line_cache #(
   parameter  int unsigned LINES  = 4,
   parameter  int unsigned TAG_W  = 13,
   parameter  int unsigned DATA_W = 128,
   localparam int unsigned IDX_W  = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [TAG_W-1:0]  tag,
   input  logic [DATA_W-1:0] fill_data,
   output logic              hit,
   output logic [DATA_W-1:0] rd_data
);
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("cache line count must be a power of two of at least 2");
   end

   logic [LINES-1:0]  match;
   logic [DATA_W-1:0] dat_arr [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic              vld;
      logic [TAG_W-1:0]  tg;
      logic [DATA_W-1:0] dt;
      logic              wr_here;

      assign wr_here = fill_en && !flush && (idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld <= 1'b0;
            tg  <= '0;
         end else if (flush) begin
            vld <= 1'b0;
         end else if (wr_here) begin
            vld <= 1'b1;
            tg  <= tag;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_here) dt <= fill_data;
      end

      assign match[i]   = vld && (tg == tag) && (idx == IDX_W'(i));
      assign dat_arr[i] = dt;
   end

   assign hit     = |match;
   assign rd_data = dat_arr[idx];

   // R11
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit);
endmodule

// File: rtl/apv_checker.sv
module apv_checker
   import apv_pkg::*;
#(
   parameter  int unsigned NUM_GROUPS    = 4,
   parameter  int unsigned ADDR_W        = 32,
   parameter  int unsigned CACHE_LINES   = 4,
   parameter  int unsigned PAGE_LOG2_MIN = 12,
   parameter  int unsigned SHIFT_W       = 3,
   localparam int unsigned GRP_W         = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cache_en,
   input  logic                         cache_flush,
   input  logic [NUM_GROUPS*ADDR_W-1:0]  cfg_base,
   input  logic [NUM_GROUPS*MODE_W-1:0]  cfg_mode,
   input  logic [NUM_GROUPS*SHIFT_W-1:0] cfg_pshift,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic                         req_write,
   input  logic [GRP_W-1:0]             req_group,
   output logic                         mem_req_valid,
   input  logic                         mem_req_ready,
   output logic [ADDR_W-1:0]            mem_req_addr,
   input  logic                         mem_rsp_valid,
   input  logic [VEC_LINE_W-1:0]        mem_rsp_data,
   output logic                         dec_valid,
   output logic                         dec_allow
);
   localparam int unsigned SEL_W  = $clog2(VEC_LINE_W);
   localparam int unsigned LIDX_W = ADDR_W - PAGE_LOG2_MIN - SEL_W;
   localparam int unsigned CIDX_W = $clog2(CACHE_LINES);
   localparam int unsigned CTAG_W = GRP_W + LIDX_W - CIDX_W;

   if (NUM_GROUPS < 1 || LIDX_W <= CIDX_W) begin : g_bad_cfg
      $error("group count or cache size out of range");
   end

   // incoming request: per-group configuration
   logic [ADDR_W-1:0]  in_base;
   logic [MODE_W-1:0]  in_mode;
   logic [SHIFT_W-1:0] in_shift;
   logic               fast_ok;

   assign in_base  = cfg_base  [req_group*ADDR_W  +: ADDR_W];
   assign in_mode  = cfg_mode  [req_group*MODE_W  +: MODE_W];
   assign in_shift = cfg_pshift[req_group*SHIFT_W +: SHIFT_W];
   assign fast_ok  = (in_mode == MODE_OFF) || (in_mode == MODE_WPROT && !req_write);

   // held request
   chk_state_e          state_q;
   logic [ADDR_W-1:0]   q_addr, q_base;
   logic [MODE_W-1:0]   q_mode;
   logic [SHIFT_W-1:0]  q_shift;
   logic [GRP_W-1:0]    q_group;
   logic [VEC_LINE_W-1:0] line_q;

   logic [LIDX_W-1:0]   ln_idx;
   logic [SEL_W-1:0]    bit_pos;
   logic [ADDR_W-1:0]   fetch_addr;

   apv_page_index #(
      .ADDR_W        (ADDR_W),
      .PAGE_LOG2_MIN (PAGE_LOG2_MIN),
      .SHIFT_W       (SHIFT_W),
      .SEL_W         (SEL_W)
   ) u_index (
      .addr       (q_addr),
      .base       (q_base),
      .shift      (q_shift),
      .line_idx   (ln_idx),
      .bit_pos    (bit_pos),
      .fetch_addr (fetch_addr)
   );

   logic                  c_hit;
   logic [VEC_LINE_W-1:0] c_rdata;
   logic                  c_fill;

   assign c_fill = (state_q == ST_WAIT) && mem_rsp_valid && cache_en;

   apv_line_cache #(
      .LINES  (CACHE_LINES),
      .TAG_W  (CTAG_W),
      .DATA_W (VEC_LINE_W)
   ) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (cache_flush),
      .fill_en   (c_fill),
      .idx       (ln_idx[CIDX_W-1:0]),
      .tag       ({q_group, ln_idx[LIDX_W-1:CIDX_W]}),
      .fill_data (mem_rsp_data),
      .hit       (c_hit),
      .rd_data   (c_rdata)
   );

   // lookup-stage decision
   logic vec_mode, lk_done, lk_allow;

   assign vec_mode = (q_mode == MODE_FULL) || (q_mode == MODE_WPROT);
   assign lk_done  = !vec_mode || (cache_en && c_hit);
   assign lk_allow = vec_mode ? !c_rdata[bit_pos] : (q_mode == MODE_PASS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         q_addr  <= '0;
         q_base  <= '0;
         q_mode  <= MODE_OFF;
         q_shift <= '0;
         q_group <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid && !fast_ok) begin
               state_q <= ST_LOOKUP;
               q_addr  <= req_addr;
               q_base  <= in_base;
               q_mode  <= in_mode;
               q_shift <= in_shift;
               q_group <= req_group;
            end
            ST_LOOKUP: state_q <= lk_done ? ST_IDLE : ST_FETCH;
            ST_FETCH:  if (mem_req_ready) state_q <= ST_WAIT;
            ST_WAIT:   if (mem_rsp_valid) state_q <= ST_RESP;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state_q == ST_WAIT && mem_rsp_valid) line_q <= mem_rsp_data;
   end

   always_comb begin
      req_ready     = (state_q == ST_IDLE);
      mem_req_valid = (state_q == ST_FETCH);
      mem_req_addr  = fetch_addr;
      dec_valid     = 1'b0;
      dec_allow     = 1'b0;
      case (state_q)
         ST_IDLE: if (req_valid && fast_ok) begin
            dec_valid = 1'b1;
            dec_allow = 1'b1;
         end
         ST_LOOKUP: if (lk_done) begin
            dec_valid = 1'b1;
            dec_allow = lk_allow;
         end
         ST_RESP: begin
            dec_valid = 1'b1;
            dec_allow = !line_q[bit_pos];
         end
         default: ;
      endcase
   end

   // ---------------- checking state ----------------
   logic rsp_pend_q, open_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_pend_q <= 1'b0;
         open_q     <= 1'b0;
      end else begin
         if (mem_req_valid && mem_req_ready) rsp_pend_q <= 1'b1;
         else if (mem_rsp_valid)             rsp_pend_q <= 1'b0;
         if (req_valid && req_ready && !dec_valid) open_q <= 1'b1;
         else if (dec_valid)                       open_q <= 1'b0;
      end
   end

   // R8
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R6
   fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[LINE_BYTES_LOG2-1:0] == '0);

   // R12
   one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !rsp_pend_q);

   // R12
   no_accept_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |-> !open_q);

   // R12
   dec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && !(req_valid && req_ready) |-> open_q);

   // R2
   fast_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && req_ready |-> dec_allow);
endmodule

// File: tb/tb_apv_checker.sv
module tb_apv_checker;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cache_en = 1'b1, cache_flush = 1'b0;
   logic [127:0]  cfg_base = '0;
   logic [11:0]   cfg_mode = '0, cfg_pshift = '0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [31:0]   req_addr = '0;
   logic [1:0]    req_group = '0;
   logic          req_ready, mem_req_valid, mem_req_ready, dec_valid, dec_allow;
   logic [31:0]   mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [127:0]  mem_rsp_data = '0;

   apv_checker dut (
      .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .cache_flush(cache_flush),
      .cfg_base(cfg_base), .cfg_mode(cfg_mode), .cfg_pshift(cfg_pshift),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_group(req_group),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .dec_valid(dec_valid), .dec_allow(dec_allow)
   );

   int checks = 0, failures = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [127:0] line_fn(logic [31:0] a);
      return {a ^ 32'h9E37_79B9, a * 32'd5, ~a, a ^ 32'hC3A5_0F1E};
   endfunction

   // memory model: response one cycle after handshake
   int stall_cfg = 0, wait_cnt = 0, fetch_cnt = 0;
   logic [31:0] last_faddr = '0;
   assign mem_req_ready = (wait_cnt >= stall_cfg);
   always @(posedge clk) begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= line_fn(mem_req_addr);
      if (mem_req_valid && mem_req_ready) begin
         wait_cnt   <= 0;
         fetch_cnt  <= fetch_cnt + 1;
         last_faddr <= mem_req_addr;
      end else if (mem_req_valid) begin
         wait_cnt <= wait_cnt + 1;
      end
   end

   task automatic check(input string rq, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   typedef struct {
      bit    allow;
      int    lat;
      int    edge_n;
      string rq;
   } exp_t;
   exp_t sb_q[$];

   // monitor
   always begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         if (sb_q.size() > 0 && sb_q[0].lat > 0 && cyc >= sb_q[0].edge_n && req_ready)
            check("R12", "req_ready while busy", 1, 0);
         if (dec_valid) begin
            if (sb_q.size() == 0) check("R12", "unexpected decision", 1, 0);
            else begin
               exp_t it;
               it = sb_q.pop_front();
               check(it.rq, "allow", dec_allow, it.allow);
               check(it.rq, "latency", cyc + 1 - it.edge_n, it.lat);
            end
         end
      end
   end

   task automatic set_grp(input int g, input logic [31:0] base, input logic [2:0] mode,
                          input logic [2:0] sh);
      cfg_base[g*32 +: 32] = base;
      cfg_mode[g*3 +: 3]   = mode;
      cfg_pshift[g*3 +: 3] = sh;
   endtask

   // vector bit expectation per R6/R7; 1 = allowed
   function automatic bit vec_allow(input logic [31:0] base, input int sh, input logic [31:0] a,
                                    output logic [31:0] fa);
      logic [31:0] line, k;
      logic [127:0] d;
      line = a >> (19 + sh);
      k    = (a >> (12 + sh)) & 32'd127;
      fa   = base + line * 16;
      d    = line_fn(fa);
      return !d[127 - k];
   endfunction

   task automatic do_req(input int g, input logic [31:0] a, input bit w, input bit ea,
                         input int lat, input int nfetch, input logic [31:0] efa, input string rq);
      int f0;
      exp_t it;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      f0 = fetch_cnt;
      req_valid = 1'b1; req_addr = a; req_write = w; req_group = 2'(g);
      it.allow = ea; it.lat = lat; it.edge_n = cyc + 1; it.rq = rq;
      sb_q.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
      wait (sb_q.size() == 0);
      @(negedge clk);
      check(rq, "fetch count", fetch_cnt - f0, nfetch);
      if (nfetch > 0) check(rq, "fetch addr", last_faddr, efa);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] fa;
      bit ea;
      set_grp(0, 32'h4000_0000, 3'd2, 3'd0);
      set_grp(1, 32'h5000_0000, 3'd1, 3'd3);
      set_grp(2, 32'h0,         3'd3, 3'd0);
      set_grp(3, 32'h6000_0000, 3'd0, 3'd7);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "req_ready", req_ready, 1);
      check("R1", "dec_valid", dec_valid, 0);
      check("R1", "mem_req_valid", mem_req_valid, 0);

      // R2 off mode
      do_req(3, 32'hABCD_0000, 1'b1, 1'b1, 0, 0, 0, "R2");
      // R3 write-protect read
      do_req(1, 32'h1234_5678, 1'b0, 1'b1, 0, 0, 0, "R3");
      // R4 passthrough and inactive
      do_req(2, 32'h0000_1000, 1'b1, 1'b1, 1, 0, 0, "R4");
      set_grp(3, 32'h6000_0000, 3'd4, 3'd7);
      do_req(3, 32'h0000_2000, 1'b0, 1'b0, 1, 0, 0, "R4");
      set_grp(3, 32'h6000_0000, 3'd6, 3'd7);
      do_req(3, 32'h0000_2000, 1'b1, 1'b0, 1, 0, 0, "R4");

      // R5/R8 full mode miss, line 1
      ea = vec_allow(32'h4000_0000, 0, 32'h0008_3000, fa);
      do_req(0, 32'h0008_3000, 1'b0, ea, 4, 1, 32'h4000_0010, "R5");
      // R9 hit with a write
      do_req(0, 32'h0008_3000, 1'b1, ea, 1, 0, 0, "R9");
      // R7 page 0 and page 127 of the same line
      ea = vec_allow(32'h4000_0000, 0, 32'h0008_0000, fa);
      do_req(0, 32'h0008_0000, 1'b0, ea, 1, 0, 0, "R7");
      ea = vec_allow(32'h4000_0000, 0, 32'h000F_F000, fa);
      do_req(0, 32'h000F_F000, 1'b0, ea, 1, 0, 0, "R7");

      // R3/R6 write-protect write, shift 3
      ea = vec_allow(32'h5000_0000, 3, 32'h1234_5678, fa);
      do_req(1, 32'h1234_5678, 1'b1, ea, 4, 1, 32'h5000_0480, "R6");

      // R8 memory stall of 3 cycles
      stall_cfg = 3;
      ea = vec_allow(32'h4000_0000, 0, 32'h0010_0000, fa);
      do_req(0, 32'h0010_0000, 1'b0, ea, 7, 1, 32'h4000_0020, "R8");
      stall_cfg = 0;

      // R6 largest page size
      set_grp(3, 32'h6000_0000, 3'd2, 3'd7);
      ea = vec_allow(32'h6000_0000, 7, 32'hFFFF_FFFF, fa);
      do_req(3, 32'hFFFF_FFFF, 1'b0, ea, 4, 1, 32'h6000_03F0, "R6");

      // R10 cache disabled
      cache_en = 1'b0;
      ea = vec_allow(32'h4000_0000, 0, 32'h0008_3000, fa);
      do_req(0, 32'h0008_3000, 1'b0, ea, 4, 1, 32'h4000_0010, "R10");
      do_req(0, 32'h0008_3000, 1'b1, ea, 4, 1, 32'h4000_0010, "R10");
      cache_en = 1'b1;

      // R11 flush
      do_req(0, 32'h0008_3000, 1'b0, ea, 1, 0, 0, "R11");
      @(negedge clk); cache_flush = 1'b1;
      @(negedge clk); cache_flush = 1'b0;
      do_req(0, 32'h0008_3000, 1'b0, ea, 4, 1, 32'h4000_0010, "R11");
      do_req(0, 32'h0008_3000, 1'b0, ea, 1, 0, 0, "R11");

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule